// File: doc/BRIEF.md
# Video Display Blanking Generator

This block produces the horizontal and vertical blanking signals of a video display port. It runs a free-running pixel position counter and line position counter from the video clock. The line length and the frame height are set by input values, so software-visible setup is applied from outside. The current pixel and line positions are brought out so neighbouring logic can place its data.

Horizontal blanking starts and ends at two programmable pixel positions. In the digital component video mode (BT.656 or Y/C), the start position is also where an end-of-active-video code belongs. The end position is also where a start-of-active-video code belongs. The block marks both positions with one-clock strobes.

In that mode an enable can hold off the end of horizontal blanking by a fixed number of clocks. The start of blanking is never held off. In raw data mode the enable has no effect. Vertical blanking starts and ends at exact (line, pixel) coordinates rather than at line boundaries. It behaves the same in both modes.

Top module: `vid_blank_gen`

## Requirements
- R1: `pix_pos` counts up by one each clock from 0. In the clock after it equals `line_len`-1 it returns to 0. At that wrap `line_pos` advances by one, and it returns to 0 instead when it equals `frame_lines`-1. Otherwise `line_pos` holds.
- R2: `hblank` goes to 1 in the clock after a clock where `pix_pos` equals `hb_start`, in both modes. When no hold-off applies, it goes to 0 in the clock after a clock where `pix_pos` equals `hb_stop`.
- R3: With `mode_raw`=0 and `hb_delay_en`=1, the fall of `hblank` after a `hb_stop` match comes 4 clocks later than in R2, i.e. in the fifth clock after the match clock. The rise is not delayed.
- R4: With `mode_raw`=1, `hb_delay_en` is ignored and `hblank` falls in the clock after the `hb_stop` match.
- R5: A `hb_stop` match while a held-off fall is still pending restarts the 4-clock hold-off. A `hb_start` match has priority over a `hb_stop` match at the same pixel, and it cancels any pending fall.
- R6: `vblank` goes to 1 in the clock after `line_pos`=`vb_start_line` and `pix_pos`=`vb_start_pix` in the same clock. It goes to 0 in the clock after `line_pos`=`vb_stop_line` and `pix_pos`=`vb_stop_pix`, and the start match wins on a tie. It is the same in both modes.
- R7: `eav_stb` is high for exactly the clock after a `hb_start` match, and `sav_stb` for exactly the clock after a `hb_stop` match. Both happen only when `mode_raw`=0; with `mode_raw`=1 both stay 0.
- R8: While `rst_n` is low, `pix_pos`, `line_pos`, `hblank`, `vblank`, `eav_stb` and `sav_stb` are all 0, and no hold-off is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | video clock |
| rst_n | input | 1 | asynchronous reset, active low |
| mode_raw | input | 1 | 1 = raw data mode, 0 = BT.656 / Y/C mode |
| line_len | input | 12 | pixels per line |
| frame_lines | input | 12 | lines per frame |
| hb_start | input | 12 | pixel where horizontal blanking starts |
| hb_stop | input | 12 | pixel where horizontal blanking ends |
| hb_delay_en | input | 1 | hold off the end of horizontal blanking (BT.656 / Y/C only) |
| vb_start_line | input | 12 | line of the vertical blanking start coordinate |
| vb_start_pix | input | 12 | pixel of the vertical blanking start coordinate |
| vb_stop_line | input | 12 | line of the vertical blanking end coordinate |
| vb_stop_pix | input | 12 | pixel of the vertical blanking end coordinate |
| pix_pos | output | 12 | current pixel position |
| line_pos | output | 12 | current line position |
| hblank | output | 1 | horizontal blanking |
| vblank | output | 1 | vertical blanking |
| eav_stb | output | 1 | one-clock mark of the blanking start position |
| sav_stb | output | 1 | one-clock mark of the blanking end position |

## Verification
The bench builds the block with its default 12-bit positions and a hold-off of 4 clocks. It programs a 20-pixel line and an 8-line frame, so pixel wraps, frame wraps and both vertical coordinates recur every 160 clocks. A later phase shortens the line to 3 pixels. Stop matches then arrive faster than the hold-off expires, which makes the restart and the start-priority cases of R5 reachable.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
  typedef enum logic {
    VMODE_CODED = 1'b0,
    VMODE_RAW   = 1'b1
  } vmode_e;

  localparam int unsigned DEF_POS_W = 12;
  localparam int unsigned DEF_HOLD  = 4;
endpackage

// File: rtl/vbg_frame_counter.sv
module vbg_frame_counter #(
  parameter int unsigned PW = 12,
  parameter int unsigned LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] line_len,
  input  logic [LW-1:0] frame_lines,
  output logic [PW-1:0] pix_q,
  output logic [LW-1:0] line_q
);
  logic [PW-1:0] last_pix;
  logic [LW-1:0] last_line;
  logic          pix_wrap;
  logic          line_wrap;

  always_comb begin
    last_pix  = line_len - 1'b1;
    last_line = frame_lines - 1'b1;
    pix_wrap  = (pix_q >= last_pix);
    line_wrap = (line_q >= last_line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (pix_wrap) begin
      pix_q  <= '0;
      line_q <= line_wrap ? '0 : line_q + 1'b1;
    end else begin
      pix_q  <= pix_q + 1'b1;
    end
  end

  // R1
  pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_wrap |=> (pix_q == '0));

  // R1
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_wrap |=> $stable(line_q));
endmodule

// File: rtl/vbg_hblank.sv
module vbg_hblank
  import vbg_pkg::*;
#(
  parameter int unsigned PW   = 12,
  parameter int unsigned HOLD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vmode_e        mode,
  input  logic          delay_en,
  input  logic [PW-1:0] pix,
  input  logic [PW-1:0] start_pos,
  input  logic [PW-1:0] stop_pos,
  output logic          hblank,
  output logic          eav_stb,
  output logic          sav_stb
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic          hit_start;
  logic          hit_stop;
  logic          hold_on;
  logic [CW-1:0] hold_cnt;

  always_comb begin
    hit_start = (pix == start_pos);
    hit_stop  = (pix == stop_pos);
    hold_on   = (mode == VMODE_CODED) && delay_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hblank   <= 1'b0;
      hold_cnt <= '0;
      eav_stb  <= 1'b0;
      sav_stb  <= 1'b0;
    end else begin
      eav_stb <= hit_start && (mode == VMODE_CODED);
      sav_stb <= hit_stop && (mode == VMODE_CODED);
      if (hit_start) begin
        hblank   <= 1'b1;
        hold_cnt <= '0;
      end else if (hit_stop && hold_on) begin
        hold_cnt <= HOLD_V;
      end else if (hit_stop) begin
        hblank   <= 1'b0;
        hold_cnt <= '0;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
        if (hold_cnt == CW'(1)) hblank <= 1'b0;
      end
    end
  end

  // R2
  hb_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_start |=> hblank);

  // R4
  hb_raw_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stop && !hit_start && mode == VMODE_RAW) |=> !hblank);

  // R3
  hb_hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_stop && !hit_start && hold_on && hblank) |=> hblank);

  // R7
  eav_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eav_stb |-> $past(mode == VMODE_CODED && hit_start));

  // R7
  sav_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sav_stb |-> $past(mode == VMODE_CODED && hit_stop));
endmodule

// File: rtl/vbg_vblank.sv
module vbg_vblank #(
  parameter int unsigned PW = 12,
  parameter int unsigned LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  input  logic [LW-1:0] set_line,
  input  logic [PW-1:0] set_pix,
  input  logic [LW-1:0] clr_line,
  input  logic [PW-1:0] clr_pix,
  output logic          vblank
);
  logic hit_set;
  logic hit_clr;

  always_comb begin
    hit_set = (line == set_line) && (pix == set_pix);
    hit_clr = (line == clr_line) && (pix == clr_pix);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vblank <= 1'b0;
    else if (hit_set) vblank <= 1'b1;
    else if (hit_clr) vblank <= 1'b0;
  end

  // R6
  vb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_set |=> vblank);

  // R6
  vb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr && !hit_set) |=> !vblank);

  // R6
  vb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_set && !hit_clr) |=> $stable(vblank));
endmodule

// File: rtl/vid_blank_gen.sv
module vid_blank_gen
  import vbg_pkg::*;
#(
  parameter int unsigned POS_W  = DEF_POS_W,
  parameter int unsigned LINE_W = DEF_POS_W,
  parameter int unsigned HOLD   = DEF_HOLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_raw,
  input  logic [POS_W-1:0]  line_len,
  input  logic [LINE_W-1:0] frame_lines,
  input  logic [POS_W-1:0]  hb_start,
  input  logic [POS_W-1:0]  hb_stop,
  input  logic              hb_delay_en,
  input  logic [LINE_W-1:0] vb_start_line,
  input  logic [POS_W-1:0]  vb_start_pix,
  input  logic [LINE_W-1:0] vb_stop_line,
  input  logic [POS_W-1:0]  vb_stop_pix,
  output logic [POS_W-1:0]  pix_pos,
  output logic [LINE_W-1:0] line_pos,
  output logic              hblank,
  output logic              vblank,
  output logic              eav_stb,
  output logic              sav_stb
);
  vmode_e mode;
  assign mode = mode_raw ? VMODE_RAW : VMODE_CODED;

  vbg_frame_counter #(.PW(POS_W), .LW(LINE_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_len    (line_len),
    .frame_lines (frame_lines),
    .pix_q       (pix_pos),
    .line_q      (line_pos)
  );

  vbg_hblank #(.PW(POS_W), .HOLD(HOLD)) u_hb (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .delay_en  (hb_delay_en),
    .pix       (pix_pos),
    .start_pos (hb_start),
    .stop_pos  (hb_stop),
    .hblank    (hblank),
    .eav_stb   (eav_stb),
    .sav_stb   (sav_stb)
  );

  vbg_vblank #(.PW(POS_W), .LW(LINE_W)) u_vb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix      (pix_pos),
    .line     (line_pos),
    .set_line (vb_start_line),
    .set_pix  (vb_start_pix),
    .clr_line (vb_stop_line),
    .clr_pix  (vb_stop_pix),
    .vblank   (vblank)
  );
endmodule

// File: tb/tb_vid_blank_gen.sv
module tb_vid_blank_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_raw = 1'b0;
  logic [11:0] line_len = 12'd20;
  logic [11:0] frame_lines = 12'd8;
  logic [11:0] hb_start = 12'd14;
  logic [11:0] hb_stop = 12'd3;
  logic        hb_delay_en = 1'b0;
  logic [11:0] vb_start_line = 12'd2;
  logic [11:0] vb_start_pix = 12'd5;
  logic [11:0] vb_stop_line = 12'd6;
  logic [11:0] vb_stop_pix = 12'd9;
  logic [11:0] pix_pos;
  logic [11:0] line_pos;
  logic        hblank, vblank, eav_stb, sav_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vid_blank_gen dut (
    .clk(clk), .rst_n(rst_n), .mode_raw(mode_raw), .line_len(line_len),
    .frame_lines(frame_lines), .hb_start(hb_start), .hb_stop(hb_stop),
    .hb_delay_en(hb_delay_en), .vb_start_line(vb_start_line),
    .vb_start_pix(vb_start_pix), .vb_stop_line(vb_stop_line),
    .vb_stop_pix(vb_stop_pix), .pix_pos(pix_pos), .line_pos(line_pos),
    .hblank(hblank), .vblank(vblank), .eav_stb(eav_stb), .sav_stb(sav_stb)
  );

  typedef struct {
    logic [11:0] px;
    logic [11:0] ln;
    logic        hb;
    logic        vb;
    logic        eav;
    logic        sav;
    string       hb_tag;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pushes the expected post-edge state
  logic [11:0] m_px = 0, m_ln = 0;
  logic        m_hb = 0, m_vb = 0;
  int          m_hold = 0;
  string       m_tag = "R2";
  always @(posedge clk) begin
    exp_t e;
    bit s_hit, p_hit, vs, vc, wrap;
    if (!rst_n) begin
      m_px = 0; m_ln = 0; m_hb = 0; m_vb = 0; m_hold = 0; m_tag = "R2";
      exp_q.delete();
    end else begin
      s_hit = (m_px == hb_start);
      p_hit = (m_px == hb_stop);
      vs = (m_ln == vb_start_line) && (m_px == vb_start_pix);
      vc = (m_ln == vb_stop_line) && (m_px == vb_stop_pix);
      e.eav = s_hit && !mode_raw;
      e.sav = p_hit && !mode_raw;
      if (s_hit) begin
        m_hb = 1; m_hold = 0; m_tag = (m_hold != 0 || p_hit) ? "R5" : "R2";
      end else if (p_hit && !mode_raw && hb_delay_en) begin
        m_tag = (m_hold != 0) ? "R5" : "R3";
        m_hold = 4;
      end else if (p_hit) begin
        m_hb = 0; m_hold = 0; m_tag = (mode_raw && hb_delay_en) ? "R4" : "R2";
      end else if (m_hold != 0) begin
        if (m_hold == 1) m_hb = 0;
        m_hold = m_hold - 1;
      end
      if (vs) m_vb = 1;
      else if (vc) m_vb = 0;
      wrap = (m_px >= line_len - 12'd1);
      if (wrap) begin
        m_px = 0;
        m_ln = (m_ln >= frame_lines - 12'd1) ? 12'd0 : m_ln + 12'd1;
      end else begin
        m_px = m_px + 12'd1;
      end
      e.px = m_px; e.ln = m_ln; e.hb = m_hb; e.vb = m_vb; e.hb_tag = m_tag;
      exp_q.push_back(e);
    end
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check("R1 pix_pos", pix_pos, e.px);
      check("R1 line_pos", line_pos, e.ln);
      check({e.hb_tag, " hblank"}, hblank, e.hb);
      check("R6 vblank", vblank, e.vb);
      check("R7 eav_stb", eav_stb, e.eav);
      check("R7 sav_stb", sav_stb, e.sav);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 pix_pos", pix_pos, 0);
    check("R8 line_pos", line_pos, 0);
    check("R8 hblank", hblank, 0);
    check("R8 vblank", vblank, 0);
    check("R8 eav_stb", eav_stb, 0);
    check("R8 sav_stb", sav_stb, 0);
    rst_n = 1'b1;
    // coded mode, no hold-off
    repeat (400) @(negedge clk);
    // R3 hold-off in coded mode
    hb_delay_en = 1'b1;
    repeat (400) @(negedge clk);
    // R4 raw mode ignores the enable; R7 strobes stay low
    mode_raw = 1'b1;
    repeat (400) @(negedge clk);
    // R5 start priority and hold-off restart with a 3-pixel line
    mode_raw = 1'b0;
    line_len = 12'd3;
    hb_start = 12'd1;
    hb_stop = 12'd0;
    repeat (60) @(negedge clk);
    hb_start = 12'd2000;
    repeat (60) @(negedge clk);
    line_len = 12'd20;
    repeat (200) @(negedge clk);
    // equal start/stop pixel and a vertical tie
    hb_start = 12'd7;
    hb_stop = 12'd7;
    vb_stop_line = 12'd2;
    vb_stop_pix = 12'd5;
    repeat (200) @(negedge clk);
    vb_stop_line = 12'd4;
    vb_stop_pix = 12'd0;
    hb_stop = 12'd11;
    mode_raw = 1'b1;
    repeat (320) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule